// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block receives configuration words for a frequency synthesizer over three asynchronous pins: a data line, a shift clock and a load strobe. All three pins first pass through a synchroniser chain into the system clock domain. Each rising edge of the synchronised shift clock moves one data bit into a 19-bit shift register, with the most significant bit sent first.

On the rising edge of the synchronised load strobe, the last bit shifted in selects where the word goes. A high routing bit sends it to the reference latch. That latch holds a 14-bit reference divide value and three single-bit controls: prescaler select, phase polarity and monitor select. A low routing bit sends it to the divider latch. That latch holds a 7-bit swallow value and an 11-bit main counter value. The latched fields drive the divider and phase logic of the synthesizer.

A word that carries a reference or main value below 5 is refused as a whole. An error flag reports the refusal, and the previous legal setting stays in place.

Top module: `synth_cfg_port`

## Requirements
- R1: On each rising edge of the synchronised shift clock, while the synchronised load strobe is low, the data bit enters bit 0 and the earlier contents move one place up. Bits shifted beyond bit 18 are lost, so only the last 19 bits sent count.
- R2: Bit 0 of the word is the routing bit. A 1 updates only the reference latch, and a 0 updates only the divider latch. The latch that is not selected keeps its contents.
- R3: Reference word layout: bits 14..1 are the reference divide value (bit 1 is the LSB), bit 15 is prescaler select, bit 16 is phase polarity and bit 17 is monitor select. Bit 18 is ignored.
- R4: Divider word layout: bits 7..1 are the swallow value (bit 1 is the LSB) and bits 18..8 are the main counter value (bit 8 is the LSB).
- R5: A transfer happens once, on the rising edge of the synchronised load strobe. Holding the strobe high, or lowering it, does not transfer again.
- R6: Shift clock edges that arrive while the load strobe is high are ignored. The shift register keeps the word it already holds.
- R7: After reset, the reference divide value is 5, the main value is 5, the swallow value is 0, all three control bits are 0 and the error flag is 0.
- R8: A reference word whose divide value is below 5 changes none of the reference fields and sets the error flag.
- R9: A divider word whose main value is below 5 changes neither divider field and sets the error flag. Any swallow value from 0 to 127 is accepted.
- R10: Any accepted transfer clears the error flag.
- R11: The limits 5, 16383 (reference) and 2047 (main) are accepted.
- R12: With the default two synchroniser stages, the outputs are still unchanged at the second clock edge after the load pin rises, and show the new value after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data pin |
| ser_clk_i | input | 1 | Serial shift clock pin |
| ser_load_i | input | 1 | Load strobe pin |
| ref_div_o | output | 14 | Latched reference divide value |
| pre_sel_o | output | 1 | Latched prescaler select |
| phase_inv_o | output | 1 | Latched phase polarity |
| mon_sel_o | output | 1 | Latched monitor select |
| swallow_o | output | 7 | Latched swallow value |
| main_div_o | output | 11 | Latched main counter value |
| ratio_err_o | output | 1 | Last transfer carried a prohibited value |

## Verification
The hardest case to reach is a shift clock edge that arrives while the load strobe is still high. Such an edge must be dropped, and the only way to see that from the ports is through a later transfer. The stimulus therefore keeps the strobe high after a divider word has been loaded and toggles the shift clock three times with data high. It then lowers the strobe and raises it again with no new bits sent. If any of those edges had been taken, the routing bit would become 1 and the reference fields would change. If all were ignored, the same divider word is loaded a second time and every output stays the same.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int REF_W     = 14;
  localparam int SWAL_W    = 7;
  localparam int MAIN_W    = 11;
  localparam int WORD_W    = 1 + SWAL_W + MAIN_W;
  localparam int REF_BITS  = REF_W + 3;
  localparam int MIN_RATIO = 5;

  typedef struct packed {
    logic              mon_sel;
    logic              phase_inv;
    logic              pre_sel;
    logic [REF_W-1:0]  ref_div;
  } ref_word_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main_div;
    logic [SWAL_W-1:0] swallow;
  } div_word_t;

  localparam ref_word_t REF_RESET = '{mon_sel: 1'b0, phase_inv: 1'b0,
                                      pre_sel: 1'b0, ref_div: REF_W'(MIN_RATIO)};
  localparam div_word_t DIV_RESET = '{main_div: MAIN_W'(MIN_RATIO),
                                      swallow: SWAL_W'(0)};
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q, chain_d;
  logic [WIDTH-1:0]             prev_q;

  always_comb begin
    chain_d[0] = pin_i;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];

  for (genvar k = 0; k < WIDTH; k++) begin : g_edge
    assign rise_o[k] = chain_q[STAGES-1][k] & ~prev_q[k];
  end
endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              load_lvl,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              take;

  assign take = shift_en & ~load_lvl;

  always_comb begin
    sr_d = {sr_q[WORD_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (take)  sr_q <= sr_d;
  end

  assign word_o = sr_q;

  // R1: a taken edge moves the data bit in at the bottom
  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_lvl) |=> (word_o[0] == $past(bit_i)) &&
                                (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])));
  // R6: nothing moves while the load strobe is high
  a_r6_frozen_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_lvl |=> $stable(word_o));
endmodule

// File: rtl/synth_cfg_latch.sv
module synth_cfg_latch
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] word_i,
  output ref_word_t         ref_o,
  output div_word_t         div_o,
  output logic              err_o
);
  ref_word_t ref_q, ref_d, cand_ref;
  div_word_t div_q, div_d, cand_div;
  logic      err_q, err_d;
  logic      to_ref, ref_ok, div_ok;

  assign to_ref   = word_i[0];
  assign cand_ref = ref_word_t'(word_i[REF_BITS:1]);
  assign cand_div = div_word_t'(word_i[WORD_W-1:1]);
  assign ref_ok   = cand_ref.ref_div >= REF_W'(MIN_RATIO);
  assign div_ok   = cand_div.main_div >= MAIN_W'(MIN_RATIO);

  always_comb begin
    ref_d = ref_q;
    div_d = div_q;
    err_d = err_q;
    if (to_ref) begin
      if (ref_ok) begin
        ref_d = cand_ref;
        err_d = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end else begin
      if (div_ok) begin
        div_d = cand_div;
        err_d = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= REF_RESET;
      div_q <= DIV_RESET;
      err_q <= 1'b0;
    end else if (load_en) begin
      ref_q <= ref_d;
      div_q <= div_d;
      err_q <= err_d;
    end
  end

  assign ref_o = ref_q;
  assign div_o = div_q;
  assign err_o = err_q;

  // R8: the latched reference value never falls below the floor
  a_r8_ref_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ref_o.ref_div >= REF_W'(MIN_RATIO));
  // R9: the latched main value never falls below the floor
  a_r9_main_floor: assert property (@(posedge clk) disable iff (!rst_n)
    div_o.main_div >= MAIN_W'(MIN_RATIO));
  // R5: without a load pulse every latch holds
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(ref_o) && $stable(div_o) && $stable(err_o));
  // R2: a reference transfer leaves the divider latch alone
  a_r2_ref_route: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && word_i[0]) |=> $stable(div_o));
  // R2: a divider transfer leaves the reference latch alone
  a_r2_div_route: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !word_i[0]) |=> $stable(ref_o));
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data_i,
  input  logic              ser_clk_i,
  input  logic              ser_load_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic              pre_sel_o,
  output logic              phase_inv_o,
  output logic              mon_sel_o,
  output logic [SWAL_W-1:0] swallow_o,
  output logic [MAIN_W-1:0] main_div_o,
  output logic              ratio_err_o
);
  localparam int LANES    = 3;
  localparam int L_DATA   = 0;
  localparam int L_CLK    = 1;
  localparam int L_LOAD   = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [LANES-1:0]  pin_lvl, pin_rise;
  logic [WORD_W-1:0] word;
  ref_word_t         ref_w;
  div_word_t         div_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  synth_cfg_sync #(.STAGES(SYNC_STAGES), .WIDTH(LANES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  ({ser_load_i, ser_clk_i, ser_data_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise)
  );

  synth_cfg_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (pin_rise[L_CLK]),
    .load_lvl (pin_lvl[L_LOAD]),
    .bit_i    (pin_lvl[L_DATA]),
    .word_o   (word)
  );

  synth_cfg_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (pin_rise[L_LOAD]),
    .word_i  (word),
    .ref_o   (ref_w),
    .div_o   (div_w),
    .err_o   (ratio_err_o)
  );

  assign ref_div_o   = ref_w.ref_div;
  assign pre_sel_o   = ref_w.pre_sel;
  assign phase_inv_o = ref_w.phase_inv;
  assign mon_sel_o   = ref_w.mon_sel;
  assign swallow_o   = div_w.swallow;
  assign main_div_o  = div_w.main_div;
endmodule

// File: tb/synth_cfg_port_bench.sv
module synth_cfg_port_bench;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_data_i = 1'b0, ser_clk_i = 1'b0, ser_load_i = 1'b0;
  logic [13:0] ref_div_o;
  logic        pre_sel_o, phase_inv_o, mon_sel_o, ratio_err_o;
  logic [6:0]  swallow_o;
  logic [10:0] main_div_o;

  typedef struct packed {
    logic [13:0] rdiv; logic pre; logic ph; logic mon;
    logic [6:0] sw; logic [10:0] mdiv; logic err;
  } exp_t;

  int   n_checks = 0, n_fail = 0;
  bit   done = 0;
  exp_t cur, last_seen;
  exp_t exp_q[$];
  string tag_q[$];
  logic [18:0] sr_model = '0;
  event  load_ev;

  always #4 clk = ~clk;

  synth_cfg_port #(.SYNC_STAGES(SYNC)) u_synth_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_data_i(ser_data_i), .ser_clk_i(ser_clk_i),
    .ser_load_i(ser_load_i), .ref_div_o(ref_div_o), .pre_sel_o(pre_sel_o),
    .phase_inv_o(phase_inv_o), .mon_sel_o(mon_sel_o), .swallow_o(swallow_o),
    .main_div_o(main_div_o), .ratio_err_o(ratio_err_o));

  function automatic exp_t actual();
    return '{rdiv: ref_div_o, pre: pre_sel_o, ph: phase_inv_o, mon: mon_sel_o,
             sw: swallow_o, mdiv: main_div_o, err: ratio_err_o};
  endfunction

  task automatic check(input string tag, input exp_t exp);
    exp_t a = actual();
    n_checks++;
    if (a !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, exp);
    end
  endtask

  // expected result of a transfer, from R2..R4 and R8..R10
  function automatic exp_t apply(exp_t c, logic [18:0] w);
    exp_t n = c;
    if (w[0]) begin
      if (w[14:1] >= 14'd5) begin
        n.rdiv = w[14:1]; n.pre = w[15]; n.ph = w[16]; n.mon = w[17]; n.err = 1'b0;
      end else n.err = 1'b1;
    end else begin
      if (w[18:8] >= 11'd5) begin
        n.sw = w[7:1]; n.mdiv = w[18:8]; n.err = 1'b0;
      end else n.err = 1'b1;
    end
    return n;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk) ser_data_i = b;
    repeat (3) @(negedge clk);
    ser_clk_i = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk_i = 1'b0;
    repeat (3) @(negedge clk);
    if (!ser_load_i) sr_model = {sr_model[17:0], b};
  endtask

  task automatic send_word(input logic [18:0] w);
    for (int i = 18; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic raise_load(input string tag);
    cur = apply(cur, sr_model);
    exp_q.push_back(cur);
    tag_q.push_back(tag);
    @(negedge clk) ser_load_i = 1'b1;
    -> load_ev;
    repeat (SYNC + 6) @(negedge clk);
  endtask

  task automatic drop_load();
    @(negedge clk) ser_load_i = 1'b0;
    repeat (SYNC + 4) @(negedge clk);
  endtask

  task automatic load(input string tag);
    raise_load(tag);
    drop_load();
  endtask

  function automatic logic [18:0] ref_word(logic [13:0] r, logic sw, logic fc, logic lds);
    return {1'b0, lds, fc, sw, r, 1'b1};
  endfunction
  function automatic logic [18:0] div_word(logic [10:0] n, logic [6:0] a);
    return {n, a, 1'b0};
  endfunction

  // monitor: pops expected results and compares them when the design updates
  initial begin
    forever begin
      @(load_ev);
      repeat (SYNC) @(negedge clk);
      check("R12 outputs not yet updated", last_seen);
      @(negedge clk);
      check(tag_q.pop_front(), exp_q[0]);
      last_seen = exp_q.pop_front();
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not end actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cur = '{rdiv: 14'd5, pre: 1'b0, ph: 1'b0, mon: 1'b0, sw: 7'd0, mdiv: 11'd5, err: 1'b0};
    last_seen = cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 reset values", cur);

    send_word(ref_word(14'd1000, 1'b1, 1'b0, 1'b1)); load("R3 R2 reference word");
    send_word(div_word(11'd100, 7'd3));               load("R4 R2 divider word");
    send_word(ref_word(14'd4, 1'b0, 1'b1, 1'b0));     load("R8 reference below 5 refused");
    send_word(ref_word(14'd5, 1'b0, 1'b1, 1'b0));     load("R10 R11 reference at 5");
    send_word(div_word(11'd4, 7'd9));                 load("R9 main below 5 refused");
    send_word(div_word(11'd2047, 7'd127));            load("R11 R10 main 2047 swallow 127");
    send_word(div_word(11'd5, 7'd0));                 load("R9 main 5 swallow 0");
    send_word(ref_word(14'd16383, 1'b1, 1'b1, 1'b1)); load("R11 reference 16383");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_word(div_word(11'd300, 7'd64));              load("R1 leading bits shifted out");

    // R5 and R6: strobe held high with shift edges, then a second strobe
    send_word(ref_word(14'd77, 1'b0, 1'b0, 1'b1));    raise_load("R5 R3 first transfer");
    repeat (20) @(negedge clk);
    check("R5 no retransfer while held", cur);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    check("R5 shift edges under load", cur);
    drop_load();
    check("R5 falling strobe no transfer", cur);
    send_word(div_word(11'd900, 7'd11));              raise_load("R4 divider before freeze test");
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    drop_load();
    load("R6 edges under load ignored");

    repeat (10) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule